// File: doc/BRIEF.md
# Phase Frequency Detector with Anti-Backlash Pulse

This block is a synchronous digital model of the phase frequency detector at the front of a charge-pump phase-locked loop. It compares a reference input with a divided feedback input. It drives an `up` flag that would switch on a positive current source and a `dn` flag that would switch on a negative one. Both inputs are asynchronous to the fast system clock. Each input passes through a synchronizer and a previous-sample register, which turns its rising edges into single-cycle events.

A rising edge on the reference sets `up` and a rising edge on the feedback sets `dn`. Once both flags are set, a common clear is armed. The clear reaches the flags only after a programmable number of system clocks. Perfectly aligned inputs therefore still produce equal, minimum-width pulses on both outputs instead of no pulse at all, which removes the dead zone around phase alignment. While the clear is pending, new input edges are dropped.

A two-bit charge-pump command is derived from the two flags. The analog current sources, the loop filter and the oscillator are not part of this block.

Top module: `pfd_antibacklash`

## Requirements
- R1: While `rst_n` is low and after its release, `up` and `dn` are 0 and `cp_cmd` is 00 until an input edge is processed.
- R2: An input value is first captured at a rising clock edge E. A rising edge on `ref_in` first captured at edge E sets `up`, which is visible after clock edge E+2. `up` then stays high until the common clear.
- R3: A rising edge on `fb_in` sets `dn` with the same latency as R2, and `dn` holds in the same way.
- R4: Let the edge at which the second flag becomes set be the clock edge where both flags are first high. With delay D = `abl_dly`, both flags clear together at D+1 clock edges later. Each flag is therefore high from its own setting edge until that clear.
- R5: Rising edges on both inputs in the same cycle make `up` and `dn` high together for exactly D+1 cycles. With D = 0 this is one cycle.
- R6: A rising edge detected while the clear is pending, before the clearing edge, is discarded. No flag is set by it after the clear.
- R7: When a rising edge is detected in the cycle in which the clear takes effect, the clear wins and the flag ends low.
- R8: The charge-pump command `cp_cmd` is 2'b00 when neither flag is high, 2'b01 for `up` only, 2'b10 for `dn` only, and 2'b11 when both are high.
- R9: When the reference edges are several times more frequent than the feedback edges, `up` is high for far more cycles than `dn`. In the reverse case, `dn` dominates.
- R10: An input held high produces no further rising-edge events and does not set its flag again after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference input, asynchronous |
| fb_in | input | 1 | Divided feedback input, asynchronous |
| abl_dly | input | 4 | Anti-backlash delay D in system clocks |
| up | output | 1 | Enables the positive current source |
| dn | output | 1 | Enables the negative current source |
| cp_cmd | output | 2 | Charge-pump command {dn, up} |

## Verification
The hardest situation to create from the ports is a fresh rising edge that lands exactly in the cycle where the pending clear expires. The edge must be placed with the synchronizer latency counted into its timing. The bench aligns both inputs with D = 4. It drops the reference low for three cycles and raises it again so that its detected rise coincides with the clearing edge, and then checks that `up` stays low. A similar re-edge in the middle of a long delay covers the discard rule. The length tables vary the relative edge offsets and D, so the pulse widths of both flags and of the net-zero command are checked against the D+1 rule.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        CP_OFF  = 2'b00,
        CP_UP   = 2'b01,
        CP_DN   = 2'b10,
        CP_BOTH = 2'b11
    } cp_cmd_e;

    localparam int N_INPUTS = 2;
    localparam int IDX_REF  = 0;
    localparam int IDX_FB   = 1;

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], din};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sync[STAGES-1] & ~st_q.prev;

    // R10: a held level never yields two events in a row
    a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/pfd_clr_timer.sv
module pfd_clr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic [W-1:0] load,
    output logic         busy,
    output logic         done
);
    typedef struct packed {
        logic         busy;
        logic [W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end else if (arm) begin
            st_d.busy = 1'b1;
            st_d.cnt  = load;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.busy && (st_q.cnt == '0);

    // R4: the pending count steps down by one each cycle
    a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=>
            (st_q.busy && st_q.cnt == $past(st_q.cnt) - {{(W-1){1'b0}}, 1'b1}));

    // R4: the timer leaves the busy state right after expiry
    a_r4_expire: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DLY_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [DLY_W-1:0] abl_dly,
    output logic             up,
    output logic             dn,
    output logic [1:0]       cp_cmd
);
    typedef struct packed {
        logic up;
        logic dn;
    } flag_state_t;

    logic [N_INPUTS-1:0] raw_in;
    logic [N_INPUTS-1:0] rise;
    logic                clr_busy;
    logic                clr_done;
    logic                arm;
    flag_state_t         fl_d, fl_q;
    cp_cmd_e             cmd;

    assign raw_in[IDX_REF] = ref_in;
    assign raw_in[IDX_FB]  = fb_in;

    for (genvar g = 0; g < N_INPUTS; g++) begin : g_edge
        pfd_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (rise[g])
        );
    end

    pfd_clr_timer #(.W(DLY_W)) u_clr (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (arm),
        .load (abl_dly),
        .busy (clr_busy),
        .done (clr_done)
    );

    always_comb begin
        fl_d = fl_q;
        if (clr_done) begin
            fl_d.up = 1'b0;
            fl_d.dn = 1'b0;
        end else if (!clr_busy) begin
            if (rise[IDX_REF]) fl_d.up = 1'b1;
            if (rise[IDX_FB])  fl_d.dn = 1'b1;
        end
        arm = !clr_busy && fl_d.up && fl_d.dn;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    always_comb begin
        unique case ({fl_q.dn, fl_q.up})
            2'b01:   cmd = CP_UP;
            2'b10:   cmd = CP_DN;
            2'b11:   cmd = CP_BOTH;
            default: cmd = CP_OFF;
        endcase
    end

    assign up     = fl_q.up;
    assign dn     = fl_q.dn;
    assign cp_cmd = cmd;

    // R2: up only rises after a detected reference edge
    a_r2_up_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.up) |-> $past(rise[IDX_REF]));

    // R3: dn only rises after a detected feedback edge
    a_r3_dn_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.dn) |-> $past(rise[IDX_FB]));

    // R4: both flags high always implies a pending clear
    a_r4_both_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.up && fl_q.dn) |-> clr_busy);

    // R7: the expiry cycle clears both flags whatever edges arrive
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_done |=> (!fl_q.up && !fl_q.dn));

    // R6: before expiry the flags are frozen high
    a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy && !clr_done) |=> (fl_q.up && fl_q.dn));

endmodule

// File: tb/pfd_antibacklash_test.sv
module pfd_antibacklash_test;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 40;
    localparam int NVEC = 6;
    // each entry {ref edge cycle, fb edge cycle, delay D}
    localparam logic [11:0] VEC [NVEC] = '{
        12'h000, 12'h003, 12'h052, 12'h610, 12'h29F, 12'h337
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic [3:0] abl_dly = 4'd0;
    logic up, dn;
    logic [1:0] cp_cmd;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_antibacklash uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .abl_dly(abl_dly), .up(up), .dn(dn), .cp_cmd(cp_cmd)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int a, b, d, m, n_up, n_dn, n_both, n_01;
        repeat (3) @(negedge clk);
        check("R1 up in reset", up, 0);
        check("R1 cp_cmd in reset", cp_cmd, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 dn after reset", dn, 0);

        // latency of R2: edge captured at E, up visible after E+2
        ref_in = 1'b1;                 // captured at edge E
        @(negedge clk); check("R2 not yet E", up, 0);
        @(negedge clk); check("R2 not yet E+1", up, 0);
        @(negedge clk); check("R2 set after E+2", up, 1);
        check("R8 up-only code 01", cp_cmd, 1);
        repeat (10) @(negedge clk);
        check("R2 up holds", up, 1);
        abl_dly = 4'd2;
        fb_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 dn not yet", dn, 0);
        @(negedge clk);
        check("R3 dn set", dn, 1);
        check("R8 both code 11", cp_cmd, 3);
        repeat (3) @(negedge clk);
        check("R4 cleared after D+1", up + dn, 0);
        check("R8 off code 00", cp_cmd, 0);
        repeat (20) @(negedge clk);
        check("R10 held inputs do not retrigger", up + dn, 0);
        idle(6);

        // vector table: R4 R5 R8 widths
        for (int v = 0; v < NVEC; v++) begin
            a = int'(VEC[v][11:8]);
            b = int'(VEC[v][7:4]);
            d = int'(VEC[v][3:0]);
            abl_dly = VEC[v][3:0];
            m = (a > b) ? a : b;
            n_up = 0; n_dn = 0; n_both = 0;
            for (int k = 0; k < WIN; k++) begin
                @(negedge clk);
                n_up   += int'(up);
                n_dn   += int'(dn);
                n_both += int'(cp_cmd == 2'b11);
                ref_in = (k >= a);
                fb_in  = (k >= b);
            end
            check($sformatf("R4 up width vec%0d", v), n_up, m - a + d + 1);
            check($sformatf("R4 dn width vec%0d", v), n_dn, m - b + d + 1);
            if (a == b)
                check($sformatf("R5 aligned pulse vec%0d", v), n_both, d + 1);
            else
                check($sformatf("R8 net-zero width vec%0d", v), n_both, d + 1);
            idle(6);
        end

        // R6: re-edge on ref in mid-delay is discarded
        abl_dly = 4'd8;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            ref_in = !(k >= 3 && k < 5);
            fb_in  = 1'b1;
        end
        check("R6 ignored up", up, 0);
        check("R6 ignored dn", dn, 0);
        idle(6);

        // R7: detected rise coincides with clear edge (D=4, clear at edge 7)
        abl_dly = 4'd4;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            ref_in = !(k >= 2 && k <= 4);
            fb_in  = 1'b1;
        end
        check("R7 clear priority up", up, 0);
        check("R7 clear priority cmd", cp_cmd, 0);
        idle(6);

        // R9: frequency dominance both ways
        abl_dly = 4'd1;
        n_up = 0; n_dn = 0; n_01 = 0;
        for (int k = 0; k < 640; k++) begin
            @(negedge clk);
            n_up += int'(up); n_dn += int'(dn);
            ref_in = (k % 8) < 4;
            fb_in  = (k % 32) < 16;
        end
        check("R9 ref faster -> up dominates", int'(n_up > 3 * n_dn), 1);
        idle(6);
        n_up = 0; n_dn = 0;
        for (int k = 0; k < 640; k++) begin
            @(negedge clk);
            n_up += int'(up); n_dn += int'(dn);
            n_01 += int'(cp_cmd == 2'b10 && !up && dn);
            ref_in = (k % 32) < 16;
            fb_in  = (k % 8) < 4;
        end
        check("R9 fb faster -> dn dominates", int'(n_dn > 3 * n_up), 1);
        check("R8 dn-only code 10 seen", int'(n_01 > 0), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule